// File: doc/BRIEF.md
# PLL Output Frequency Decoder

This block works out the output frequency, in hertz, that a clock synthesizer produces for a given 32-bit control word. The reference frequency is fixed at 33,333,333 Hz. A caller presents the control word together with a one-cycle start pulse. Some cycles later the block raises a valid flag, and the frequency sits on a 64-bit output. Both stay put until the next accepted start.

The word carries three divider codes, and none of them maps linearly to its divider value. The input divisor is the input code plus one. The feedback multiplier is twice the feedback code plus one. The output divisor is two raised to the output code. Two control bits skip the arithmetic entirely: power-down reports zero, and bypass reports the reference. In every other case the block forms the product of the reference and the multiplier in 40 bits. It then divides that product by the combined divisor with a restoring shift-subtract loop, which takes one quotient bit per cycle.

Top module: `pll_freq_decoder`

## Requirements
- R1: When bit 0 (power-down) of the captured word is 1, the reported frequency is 0, whatever the other bits hold.
- R2: When bit 0 is 0 and bit 1 (bypass) is 1, the reported frequency is 33,333,333.
- R3: The input divisor equals the 5-bit field at bits 8:4 plus one.
- R4: The feedback multiplier equals 2 × (the 7-bit field at bits 15:9 plus one).
- R5: The output divisor equals 2 raised to the 2-bit field at bits 3:2.
- R6: Otherwise the frequency is floor(33,333,333 × multiplier / (input divisor × output divisor)), and bits 31:16 of the word have no effect on it.
- R7: The cycle after a start is accepted, the valid flag reads 0.
- R8: Valid rises no later than 43 cycles after the accepted start. It then stays high, with the frequency unchanged, until the next start.
- R9: A start that arrives while a computation is running is ignored, and the result belongs to the word captured first.
- R10: After reset, valid is 0 and the frequency output is 0.
- R11: The largest product (multiplier 256, divisor 1) comes out exactly as 8,533,333,248, and the output never exceeds 40 significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; accepted only while idle |
| ctrlWord | input | 32 | Synthesizer control word, captured on an accepted start |
| freqHz | output | 64 | Decoded frequency in hertz |
| freqValid | output | 1 | High while freqHz holds the result of the last accepted start |

## Verification
The checker asserts the following on every cycle: valid clears after an accepted start, valid and the result hold steady once valid, the computation finishes within the latency bound, the two short-circuit values are correct, and the upper output bits stay clear. Only the bench scenarios can show that the divider codes decode correctly and that truncation is exact. That takes known words with hand-computed frequencies, including the extreme multiplier and divisor. The bench scenarios also show that an overlapping start is dropped and that the unused upper bits are ignored.

// File: rtl/pllfd_pkg.sv
package pllfd_pkg;
  // Bit positions inside the control word; the decode depends on them.
  localparam int PD_BIT   = 0;
  localparam int BYP_BIT  = 1;
  localparam int OD_LSB   = 2;
  localparam int ID_LSB   = 4;
  localparam int FB_LSB   = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } fsmState_t;

  typedef struct packed {
    logic capture;  // latch the control word, drop valid
    logic prep;     // load the dividend and divisor, or a short-circuit value
    logic step;     // one restoring-division iteration
    logic finish;   // publish the quotient and raise valid
  } dpStrobe_t;
endpackage

// File: rtl/pllfd_field_decode.sv
module pllfd_field_decode
  import pllfd_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter int IDIV_W = 5,
  parameter int FB_W   = 7,
  parameter int OD_W   = 2,
  localparam int MULT_W = FB_W + 2,
  localparam int DIVR_W = IDIV_W + 1 + (2 ** OD_W) - 1
) (
  input  logic [CTRL_W-1:0] word,
  output logic              powerDown,
  output logic              bypass,
  output logic [MULT_W-1:0] mult,
  output logic [DIVR_W-1:0] divisor
);
  logic [IDIV_W-1:0] idField;
  logic [FB_W-1:0]   fbField;
  logic [OD_W-1:0]   odField;
  logic [FB_W:0]     fbPlus;
  logic [IDIV_W:0]   idPlus;

  always_comb begin
    powerDown = word[PD_BIT];
    bypass    = word[BYP_BIT];
    idField   = word[ID_LSB +: IDIV_W];
    fbField   = word[FB_LSB +: FB_W];
    odField   = word[OD_LSB +: OD_W];
    fbPlus    = {1'b0, fbField} + 1'b1;
    idPlus    = {1'b0, idField} + 1'b1;
    mult      = {fbPlus, 1'b0};
    divisor   = DIVR_W'(idPlus) << odField;
  end
endmodule

// File: rtl/pllfd_ctrl.sv
module pllfd_ctrl
  import pllfd_pkg::*;
#(
  parameter int PROD_W = 40,
  localparam int CNT_W = $clog2(PROD_W + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      shortCut,
  output dpStrobe_t strobe,
  output logic      busy
);
  fsmState_t stateQ, stateD;
  logic [CNT_W-1:0] stepCntQ;
  logic lastStep;

  assign lastStep = (stepCntQ == CNT_W'(PROD_W - 1));

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        strobe.capture = 1'b1;
        stateD = ST_PREP;
      end
      ST_PREP: begin
        strobe.prep = 1'b1;
        stateD = shortCut ? ST_FIN : ST_RUN;
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (lastStep) stateD = ST_FIN;
      end
      ST_FIN: begin
        strobe.finish = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      stepCntQ <= '0;
    end else begin
      stateQ <= stateD;
      if (strobe.prep)      stepCntQ <= '0;
      else if (strobe.step) stepCntQ <= stepCntQ + 1'b1;
    end
  end

  assign busy = (stateQ != ST_IDLE);
endmodule

// File: rtl/pllfd_datapath.sv
module pllfd_datapath
  import pllfd_pkg::*;
#(
  parameter int          CTRL_W = 32,
  parameter int          IDIV_W = 5,
  parameter int          FB_W   = 7,
  parameter int          OD_W   = 2,
  parameter int          PROD_W = 40,
  parameter int          OUT_W  = 64,
  parameter int unsigned REF_HZ = 33333333,
  localparam int MULT_W = FB_W + 2,
  localparam int DIVR_W = IDIV_W + 1 + (2 ** OD_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic              shortCut,
  output logic [OUT_W-1:0]  freqHz,
  output logic              freqValid
);
  logic [CTRL_W-1:0] wordQ;
  logic [PROD_W-1:0] quoQ;
  logic [DIVR_W-1:0] remQ;
  logic [DIVR_W-1:0] divQ;
  logic [OUT_W-1:0]  freqQ;
  logic              validQ;

  logic              powerDown, bypass;
  logic [MULT_W-1:0] mult;
  logic [DIVR_W-1:0] divisor;
  logic [PROD_W-1:0] product;
  logic [DIVR_W:0]   shifted;
  logic              fits;

  pllfd_field_decode #(
    .CTRL_W(CTRL_W), .IDIV_W(IDIV_W), .FB_W(FB_W), .OD_W(OD_W)
  ) u_decode (
    .word(wordQ), .powerDown(powerDown), .bypass(bypass),
    .mult(mult), .divisor(divisor)
  );

  assign shortCut = powerDown | bypass;
  assign product  = PROD_W'(REF_HZ) * PROD_W'(mult);
  assign shifted  = {remQ, quoQ[PROD_W-1]};
  assign fits     = (shifted >= {1'b0, divQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ  <= '0;
      quoQ   <= '0;
      remQ   <= '0;
      divQ   <= '0;
      freqQ  <= '0;
      validQ <= 1'b0;
    end else begin
      if (strobe.capture) begin
        wordQ  <= ctrlWord;
        validQ <= 1'b0;
      end
      if (strobe.prep) begin
        remQ <= '0;
        divQ <= divisor;
        if (powerDown)   quoQ <= '0;
        else if (bypass) quoQ <= PROD_W'(REF_HZ);
        else             quoQ <= product;
      end
      if (strobe.step) begin
        quoQ <= {quoQ[PROD_W-2:0], fits};
        remQ <= fits ? DIVR_W'(shifted - {1'b0, divQ}) : shifted[DIVR_W-1:0];
      end
      if (strobe.finish) begin
        freqQ  <= OUT_W'(quoQ);
        validQ <= 1'b1;
      end
    end
  end

  assign freqHz    = freqQ;
  assign freqValid = validQ;
endmodule

// File: rtl/pll_freq_decoder.sv
module pll_freq_decoder
  import pllfd_pkg::*;
#(
  parameter int          CTRL_W = 32,
  parameter int          IDIV_W = 5,
  parameter int          FB_W   = 7,
  parameter int          OD_W   = 2,
  parameter int          PROD_W = 40,
  parameter int          OUT_W  = 64,
  parameter int unsigned REF_HZ = 33333333
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic [OUT_W-1:0]  freqHz,
  output logic              freqValid
);
  dpStrobe_t strobe;
  logic      shortCut;
  logic      busy;

  pllfd_ctrl #(.PROD_W(PROD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .shortCut(shortCut),
    .strobe(strobe), .busy(busy)
  );

  pllfd_datapath #(
    .CTRL_W(CTRL_W), .IDIV_W(IDIV_W), .FB_W(FB_W), .OD_W(OD_W),
    .PROD_W(PROD_W), .OUT_W(OUT_W), .REF_HZ(REF_HZ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctrlWord(ctrlWord),
    .shortCut(shortCut), .freqHz(freqHz), .freqValid(freqValid)
  );
endmodule

// File: rtl/pllfd_checker.sv
module pllfd_checker #(
  parameter int          CTRL_W = 32,
  parameter int          PROD_W = 40,
  parameter int          OUT_W  = 64,
  parameter int unsigned REF_HZ = 33333333
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic [OUT_W-1:0]  freqHz,
  input logic              freqValid
);
  logic capPd, capByp;
  int   latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPd  <= 1'b0;
      capByp <= 1'b0;
      latCnt <= 0;
    end else if (start && !busy) begin
      capPd  <= ctrlWord[0];
      capByp <= ctrlWord[1];
      latCnt <= 1;
    end else if (busy) begin
      latCnt <= latCnt + 1;
    end
  end

  // R1
  pd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(freqValid) && capPd |-> freqHz == '0);
  // R2
  bypass_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(freqValid) && !capPd && capByp |-> freqHz == OUT_W'(REF_HZ));
  // R7
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> !freqValid);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    freqValid && !start |=> freqValid && $stable(freqHz));
  // R8
  latency_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> latCnt <= PROD_W + 2);
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    freqHz[OUT_W-1:PROD_W] == '0);
endmodule

bind pll_freq_decoder pllfd_checker #(
  .CTRL_W(CTRL_W), .PROD_W(PROD_W), .OUT_W(OUT_W), .REF_HZ(REF_HZ)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .ctrlWord(ctrlWord), .freqHz(freqHz), .freqValid(freqValid)
);

// File: tb/pll_freq_decoder_tb.sv
module pll_freq_decoder_tb;
  localparam int N_VEC = 12;
  localparam int LAT_MAX = 43;

  // word, expected frequency, requirement
  localparam logic [31:0] VEC_WORD [N_VEC] = '{
    32'h0000_160C, 32'h0000_5E1C, 32'h0000_3A10, 32'h0000_2A08,
    32'h0000_1640, 32'h0000_1604, 32'h0000_0060, 32'h0000_FE00,
    32'h0000_01FC, 32'hABCD_160C, 32'hFFFF_FFFF, 32'h0000_5E1E
  };
  localparam logic [63:0] VEC_EXP [N_VEC] = '{
    64'd99999999, 64'd199999998, 64'd999999990, 64'd366666663,
    64'd159999998, 64'd399999996, 64'd9523809, 64'd8533333248,
    64'd260416, 64'd99999999, 64'd0, 64'd33333333
  };
  localparam string VEC_REQ [N_VEC] = '{
    "R6", "R3", "R4", "R4", "R3", "R5", "R6", "R11",
    "R5", "R6", "R1", "R2"
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic [63:0] freqHz;
  logic        freqValid;
  int          nChecks = 0;
  int          nFail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  pll_freq_decoder u_dut (
    .clk(clk), .rstN(rstN), .start(start), .ctrlWord(ctrlWord),
    .freqHz(freqHz), .freqValid(freqValid)
  );

  task automatic checkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [31:0] w);
    @(negedge clk);
    start = 1'b1;
    ctrlWord = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitValid(output int lat);
    lat = 1;
    while (!freqValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runOne(input logic [31:0] w, input logic [63:0] exp, input string req);
    int lat;
    pulseStart(w);
    checkEq("R7", 64'(freqValid), 64'd0);
    waitValid(lat);
    checkEq(req, freqHz, exp);
    checkEq("R8", 64'(lat <= LAT_MAX), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int lat;
    // R10: state during and after reset
    repeat (3) @(negedge clk);
    checkEq("R10", 64'(freqValid), 64'd0);
    checkEq("R10", freqHz, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R10", 64'(freqValid), 64'd0);
    checkEq("R10", freqHz, 64'd0);

    for (int i = 0; i < N_VEC; i++) begin
      runOne(VEC_WORD[i], VEC_EXP[i], VEC_REQ[i]);
    end

    // R9: second start during a run is dropped
    pulseStart(32'h0000_160C);
    repeat (5) @(negedge clk);
    start = 1'b1;
    ctrlWord = 32'h0000_FE00;
    @(negedge clk);
    start = 1'b0;
    waitValid(lat);
    checkEq("R9", freqHz, 64'd99999999);

    // R8: result holds without a new start
    repeat (20) @(negedge clk);
    checkEq("R8", 64'(freqValid), 64'd1);
    checkEq("R8", freqHz, 64'd99999999);

    // R1: power-down wins over bypass and fields
    runOne(32'h0000_FE03, 64'd0, "R1");
    // R2: bypass ignores the divider fields
    runOne(32'h0000_01FE, 64'd33333333, "R2");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule